// File: doc/BRIEF.md
# Multiprocessor Serial Transmitter with Status Flags

This block sends bytes over an asynchronous serial line and adds one extra address/data marker bit to every character, so that several receivers sharing one line can tell address characters from data characters. Software writes a byte into a one-byte holding register and then hands it over by clearing an "empty" flag. The block moves the byte into a shift register as soon as the line is free, or the moment the current character is ending. Each character on the line is a low start bit, eight data bits with the least significant bit first, the marker bit, and one high stop bit. Every bit lasts `BIT_CYCLES` clock cycles. When nothing is sent the line is high.

A small status register reports four things: the empty flag, a "line finished" flag, the marker bit most recently captured by the receiver, and the marker bit that will go into the next outgoing character. The two handshake flags follow a read-then-clear rule: a 0 written to the empty flag clears it, and the line-finished flag with it, only if software read the empty flag as 1 since the previous status write. Removing transmit enable, or asserting standby, stops the shifter and forces the line-finished flag to 1.

Top module: `mpx_uart_tx`

## Requirements
- R1: After reset the status register reads 0x03 (empty=1, line-finished=1, received marker=0, outgoing marker=0), the holding register reads 0x00 and the line is high.
- R2: Register map: address 0 is the holding register (read/write). Address 1 is the status register: bit 0 empty, bit 1 line-finished, bit 2 received marker, bit 3 outgoing marker, bits 7:4 read 0. A character is a 0 start bit, data bits 0 to 7, the marker bit, then a 1 stop bit, each held for exactly `BIT_CYCLES` cycles.
- R3: When the shifter is idle, transmission is enabled and empty=0, the byte is loaded on the next clock edge, empty returns to 1 on that edge, and the start bit begins in the cycle after it.
- R4: If empty=0 when the stop bit of the current character ends, the next start bit follows in the very next cycle, with no idle cycle.
- R5: If empty=1 when the stop bit ends, line-finished becomes 1 and the line returns high.
- R6: While transmit enable is 0 or standby is 1, line-finished is forced to 1 and the line is high from the next cycle on, even in the middle of a character.
- R7: Writing 0 to status bit 0 clears empty and line-finished only if status was read with empty=1 after the last status write. A 0 written without such a read, or a 1 written, leaves both flags as they were.
- R8: Line-finished is read-only: a value written to status bit 1 has no effect.
- R9: Status bit 3 is read/write and resets to 0. Its value when a byte is loaded becomes that character's marker bit.
- R10: With receive enable at 1, a receiver strobe copies the incoming marker bit into status bit 2. With receive enable at 0 the bit keeps its value. Writes to bit 2 have no effect.
- R11: When a clearing status write lands on the same edge as the end of a stop bit with empty=1, the clear wins: line-finished reads 0 afterwards, the line stays high for one cycle, and then the new character starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 holding register, 1 status |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, gates marker capture |
| standby | input | 1 | Low-power request, stops transmission |
| rx_mpb | input | 1 | Marker bit of the character just received |
| rx_mpb_valid | input | 1 | Strobe qualifying rx_mpb |
| txd | output | 1 | Serial line output, idles high |

## Verification
The software clear of the handshake flags and the end of a character's stop bit can land on the same clock edge. One would set line-finished and the other would clear it. The bench provokes this by timing a data write, a status read and a clearing write so that the last of them hits the final edge of the stop bit. It then judges the result at the ports: line-finished must read 0, the line must stay high for exactly one cycle, and the following character must match its reference waveform bit for bit. The same data-write, read and clear sequence, placed early in a character, separately confirms that characters go out back to back.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_RXMP  = 2;
  localparam int ST_TXMP  = 3;

  // character image, bit 0 goes out first
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                        input logic mp);
    return {1'b1, mp, d, 1'b0};
  endfunction
endpackage

// File: rtl/mpx_tx_status.sv
module mpx_tx_status
  import mpx_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_off,
  input  logic              rx_en,
  input  logic              rx_mpb,
  input  logic              rx_mpb_valid,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_evt,
  input  logic              fin_evt,
  output logic              empty_q,
  output logic              done_q,
  output logic              rxmp_q,
  output logic              txmp_q,
  output logic              armed_q,
  output logic              sw_clear
);
  // clear is honoured only after empty was seen as 1
  assign sw_clear = stat_wr && armed_q && !wdata[ST_EMPTY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      done_q  <= 1'b1;
      rxmp_q  <= 1'b0;
      txmp_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (sw_clear)      empty_q <= 1'b0;
      else if (load_evt) empty_q <= 1'b1;

      if (tx_off)                   done_q <= 1'b1;
      else if (sw_clear)            done_q <= 1'b0;
      else if (fin_evt && empty_q)  done_q <= 1'b1;

      if (stat_wr)                  armed_q <= 1'b0;
      else if (stat_rd && empty_q)  armed_q <= 1'b1;

      if (stat_wr) txmp_q <= wdata[ST_TXMP];

      if (rx_en && rx_mpb_valid) rxmp_q <= rx_mpb;
    end
  end
endmodule

// File: rtl/mpx_tx_shifter.sv
module mpx_tx_shifter
  import mpx_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_on,
  input  logic              full,
  input  logic [DATA_W-1:0] data,
  input  logic              mp,
  output logic              load_evt,
  output logic              fin_evt,
  output logic              txd
);
  localparam int CYC_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [CYC_W-1:0]      cyc_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  bit_end;

  assign bit_end  = (cyc_q == CYC_LAST);
  assign fin_evt  = busy_q && bit_end && (idx_q == IDX_LAST);
  assign load_evt = tx_on && full && (!busy_q || fin_evt);
  assign txd      = busy_q ? frame_q[idx_q] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cyc_q   <= '0;
      idx_q   <= '0;
      frame_q <= '1;
    end else if (!tx_on) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      idx_q  <= '0;
    end else if (load_evt) begin
      busy_q  <= 1'b1;
      cyc_q   <= '0;
      idx_q   <= '0;
      frame_q <= build_frame(data, mp);
    end else if (fin_evt) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (bit_end) begin
        cyc_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx
  import mpx_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              standby,
  input  logic              rx_mpb,
  input  logic              rx_mpb_valid,
  output logic              txd
);
  logic              stat_rd, stat_wr, data_wr, tx_off;
  logic              load_evt, fin_evt, sw_clear;
  logic              empty_q, done_q, rxmp_q, txmp_q, armed_q;
  logic [DATA_W-1:0] hold_q;

  assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);
  assign stat_wr = bus_wr && (bus_addr == ADDR_STAT);
  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign tx_off  = !tx_en || standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (data_wr) hold_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_DATA) begin
      bus_rdata = hold_q;
    end else begin
      bus_rdata[ST_EMPTY] = empty_q;
      bus_rdata[ST_DONE]  = done_q;
      bus_rdata[ST_RXMP]  = rxmp_q;
      bus_rdata[ST_TXMP]  = txmp_q;
    end
  end

  mpx_tx_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_off       (tx_off),
    .rx_en        (rx_en),
    .rx_mpb       (rx_mpb),
    .rx_mpb_valid (rx_mpb_valid),
    .stat_rd      (stat_rd),
    .stat_wr      (stat_wr),
    .wdata        (bus_wdata),
    .load_evt     (load_evt),
    .fin_evt      (fin_evt),
    .empty_q      (empty_q),
    .done_q       (done_q),
    .rxmp_q       (rxmp_q),
    .txmp_q       (txmp_q),
    .armed_q      (armed_q),
    .sw_clear     (sw_clear)
  );

  mpx_tx_shifter #(.BIT_CYCLES(BIT_CYCLES)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_on    (!tx_off),
    .full     (!empty_q),
    .data     (hold_q),
    .mp       (txmp_q),
    .load_evt (load_evt),
    .fin_evt  (fin_evt),
    .txd      (txd)
  );
endmodule

// File: rtl/mpx_uart_tx_chk.sv
module mpx_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_off,
  input logic rx_en,
  input logic stat_wr,
  input logic load_evt,
  input logic fin_evt,
  input logic sw_clear,
  input logic armed_q,
  input logic empty_q,
  input logic done_q,
  input logic rxmp_q,
  input logic txd
);
  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> empty_q);  // R3
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd);  // R3
  AST_FIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && empty_q && !sw_clear) |=> (done_q && txd));  // R5
  AST_OFF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off |=> done_q);  // R6
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off |=> txd);  // R6
  AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !armed_q && empty_q) |=> empty_q);  // R7
  AST_DONE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !sw_clear && !tx_off && !(fin_evt && empty_q)) |=> $stable(done_q));  // R8
  AST_RXMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(rxmp_q));  // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && fin_evt && !tx_off) |=> !done_q);  // R11
endmodule

bind mpx_uart_tx mpx_uart_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_off   (tx_off),
  .rx_en    (rx_en),
  .stat_wr  (stat_wr),
  .load_evt (load_evt),
  .fin_evt  (fin_evt),
  .sw_clear (sw_clear),
  .armed_q  (armed_q),
  .empty_q  (empty_q),
  .done_q   (done_q),
  .rxmp_q   (rxmp_q),
  .txd      (txd)
);

// File: tb/sim_mpx_uart_tx.sv
module sim_mpx_uart_tx;
  localparam int CLK_PERIOD = 10;
  localparam int BITC       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_en = 1'b1, rx_en = 1'b0, standby = 1'b0;
  logic       rx_mpb = 1'b0, rx_mpb_valid = 1'b0;
  logic       txd;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpx_uart_tx #(.BIT_CYCLES(BITC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_en(tx_en), .rx_en(rx_en),
    .standby(standby), .rx_mpb(rx_mpb), .rx_mpb_valid(rx_mpb_valid), .txd(txd)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the next one
  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // expected line level of bit i of a character
  function automatic int exp_bit(input logic [7:0] d, input logic mp, input int i);
    if (i == 0) return 0;
    if (i <= 8) return int'((d >> (i - 1)) & 8'h01);
    if (i == 9) return int'(mp);
    return 1;
  endfunction

  // starts in cycle 0 of the start bit, ends in the cycle after the stop bit
  task automatic check_frame(input logic [7:0] d, input logic mp, input string req);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      check(req, int'(txd), exp_bit(d, mp, i));
      repeat (BITC - 1) @(negedge clk);
    end
  endtask

  // hands a byte over; returns in cycle 0 of its start bit
  task automatic queue_byte(input logic [7:0] d, input logic mp);
    logic [7:0] v;
    wr(1'b1, {4'b0, mp, 3'b001});
    wr(1'b0, d);
    rd(1'b1, v);
    check("R7 empty before clear", int'(v[0]), 1);
    check("R9 marker readback", int'(v[3]), int'(mp));
    wr(1'b1, {4'b0, mp, 3'b000});
    rd(1'b1, v);
    check("R7 empty cleared", int'(v[0]), 0);
    check("R7 finished cleared", int'(v[1]), 0);
  endtask

  task automatic end_idle(input string req);
    logic [7:0] v;
    check(req, int'(txd), 1);
    rd(1'b1, v);
    check(req, int'(v[1:0]), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b1, v); check("R1 status", int'(v), 8'h03);
    rd(1'b0, v); check("R1 holding", int'(v), 0);
    check("R1 line idle", int'(txd), 1);

    // R7 clear without prior read: that read above armed, so disarm first
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    check("R7 no start when unarmed", int'(txd), 1);
    rd(1'b1, v); check("R7 unarmed zero ignored", int'(v[1:0]), 3);
    // armed now; write 1 to empty, 0 to finished, 1 to rx marker, 1 to tx marker
    wr(1'b1, 8'h0D);
    rd(1'b1, v); check("R8 R10 R9 write mix", int'(v), 8'h0B);
    wr(1'b1, 8'h01);
    rd(1'b1, v); check("R9 marker back to 0", int'(v), 8'h03);

    // R10 received marker capture and hold
    rx_en = 1'b1; rx_mpb = 1'b1; rx_mpb_valid = 1'b1;
    @(negedge clk); rx_mpb_valid = 1'b0;
    rd(1'b1, v); check("R10 capture 1", int'(v[2]), 1);
    rx_en = 1'b0; rx_mpb = 1'b0; rx_mpb_valid = 1'b1;
    @(negedge clk); rx_mpb_valid = 1'b0;
    rd(1'b1, v); check("R10 held while disabled", int'(v[2]), 1);
    rx_en = 1'b1; rx_mpb_valid = 1'b1;
    @(negedge clk); rx_mpb_valid = 1'b0;
    rd(1'b1, v); check("R10 capture 0", int'(v[2]), 0);

    // R2 R3 R5 sweep over every byte value
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b = 8'(d);
      queue_byte(b, ^b);
      check_frame(b, ^b, "R2 frame bit");
      end_idle("R5 finished and idle");
    end

    // R4 back-to-back characters
    queue_byte(8'h3C, 1'b1);
    fork
      check_frame(8'h3C, 1'b1, "R4 first frame");
      begin
        logic [7:0] w;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'hC5);
        rd(1'b1, w);
        check("R3 empty set by load", int'(w[0]), 1);
        wr(1'b1, 8'h00);
      end
    join
    check_frame(8'hC5, 1'b0, "R4 second frame no gap");
    end_idle("R5 after pair");

    // R11 clear on the final edge of the stop bit
    queue_byte(8'h81, 1'b0);
    fork
      check_frame(8'h81, 1'b0, "R11 first frame");
      begin
        logic [7:0] w;
        repeat (41) @(negedge clk);
        wr(1'b0, 8'h6E);
        rd(1'b1, w);
        check("R11 empty before clear", int'(w[0]), 1);
        wr(1'b1, 8'h08);
      end
    join
    check("R11 one idle cycle", int'(txd), 1);
    rd(1'b1, v);
    check("R11 clear wins", int'(v[1:0]), 0);
    check_frame(8'h6E, 1'b1, "R11 next frame");
    end_idle("R5 after R11");

    // R6 transmit enable removed mid-character
    queue_byte(8'h00, 1'b0);
    repeat (5) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check("R6 line high on disable", int'(txd), 1);
    rd(1'b1, v); check("R6 finished forced", int'(v[1]), 1);
    tx_en = 1'b1;
    @(negedge clk);
    check("R6 stays idle", int'(txd), 1);

    // R6 standby mid-character
    queue_byte(8'h00, 1'b0);
    repeat (3) @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    check("R6 line high in standby", int'(txd), 1);
    rd(1'b1, v); check("R6 finished in standby", int'(v[1]), 1);
    standby = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule